// File: doc/BRIEF.md
# Multicycle Execution Unit Pool

A group of five execution units sits behind one issue port: a single-cycle integer unit, an address unit for loads and stores, a four-stage pipelined adder, a seven-stage pipelined multiplier and an iterative divider that holds one operation at a time. The issuer presents an operation with a unit code, a destination tag and two operands. It may only present an operation to a unit whose ready bit is high. Arithmetic is a simple placeholder for each unit.

Every unit feeds a common fixed-priority writeback arbiter. The winner passes through a shared memory register and a writeback register before it reaches the ports. A unit that loses arbitration freezes its whole pipeline with the result held in its last stage, and drops its ready bit until the result has been granted. Each completion reports the unit, the tag given at issue and the result.

Top module: `fu_pool`

## Requirements
- R1: While reset is high, and on the first cycle after it, all five ready bits are high and `wb_valid` is low.
- R2: Unit code 0 (integer) returns `a ^ b`. With no contention, `wb_valid` rises two cycles after the clock edge that accepts the issue.
- R3: Unit code 1 (load/store address) returns `a + b`. With no contention, the result appears three cycles after acceptance.
- R4: Unit code 2 (adder) returns `a + b` and appears five cycles after acceptance. It accepts a new operation on every cycle, so back-to-back issues complete on consecutive cycles.
- R5: Unit code 3 (multiplier) returns the low DATA_W bits of `a * b` and appears eight cycles after acceptance. It accepts one operation per cycle.
- R6: Unit code 4 (divider) returns the unsigned quotient `a / b`. A divisor of zero gives all ones. The result appears 26 cycles after acceptance.
- R7: After the divider accepts an operation, its ready bit is low for exactly 25 cycles. A divide issued while that bit is low is ignored and produces no completion.
- R8: At most one completion leaves per cycle. When several units finish in the same cycle, the higher unit code wins, so the divider has top priority and the integer unit the lowest. A losing unit holds its result and keeps its ready bit low until it is granted. Its completion then leaves one cycle later per cycle of delay.
- R9: Each completion carries its issue tag and unit code on `wb_tag` and `wb_unit`. Completions from one unit leave in issue order, and every accepted operation completes exactly once.
- R10: An issue with a unit code of 5 to 7 is ignored. No completion follows, and all ready bits stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is presented this cycle |
| iss_unit | input | 3 | Target unit code, 0 to 4 |
| iss_tag | input | TAG_W | Destination tag |
| iss_a | input | DATA_W | First operand |
| iss_b | input | DATA_W | Second operand |
| unit_ready | output | 5 | Bit n high: unit n can accept this cycle |
| wb_valid | output | 1 | A completion is present |
| wb_unit | output | 3 | Unit that produced the completion |
| wb_tag | output | TAG_W | Destination tag of the completion |
| wb_data | output | DATA_W | Result |

## Verification
A completion is due 2, 3, 5, 8 or 26 cycles after its accepting edge, for unit codes 0 to 4. That edge is counted as the one after the negative edge at which the driver presents the operation. Each expected item carries its due cycle: the accepting edge plus the unit's delay, plus one cycle for each arbitration loss that the test deliberately sets up. The monitor samples on the falling edge and compares the unit, tag, data and arrival cycle against the oldest pending item of that unit. Ready bits are checked in the exact cycles where the divider window closes and where a stalled unit holds its result.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = 3;

  typedef enum logic [UNIT_W-1:0] {
    U_INT = 3'd0,
    U_LS  = 3'd1,
    U_ADD = 3'd2,
    U_MUL = 3'd3,
    U_DIV = 3'd4
  } unit_e;
endpackage

// File: rtl/fu_pipe.sv
module fu_pipe
  import fu_pkg::*;
#(
  parameter int    DEPTH  = 4,
  parameter int    DATA_W = 16,
  parameter int    TAG_W  = 6,
  parameter unit_e KIND   = U_ADD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              grant,
  output logic              ready,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DATA_W-1:0] res;
  logic              hold;

  always_comb begin
    case (KIND)
      U_INT:   res = in_a ^ in_b;
      U_MUL:   res = in_a * in_b;
      default: res = in_a + in_b;
    endcase
  end

  assign hold = vld_q[DEPTH-1] & ~grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (!hold) begin
      vld_q[0] <= in_valid;
      for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      tag_q[0] <= in_tag;
      dat_q[0] <= res;
      for (int i = 1; i < DEPTH; i++) begin
        tag_q[i] <= tag_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end
  end

  assign ready     = ~hold;
  assign out_valid = vld_q[DEPTH-1];
  assign out_tag   = tag_q[DEPTH-1];
  assign out_data  = dat_q[DEPTH-1];

  // R8: a result that loses arbitration stays put, unchanged
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !grant) |=> (out_valid && $stable(out_tag) && $stable(out_data)));

  // R8: the issuer is never let into a frozen pipeline
  assert_no_issue_when_held_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ready);
endmodule

// File: rtl/fu_div.sv
module fu_div #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int II     = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              grant,
  output logic              ready,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(II);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rem_q, quo_q, dvs_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W:0]   trial;
  logic              finish;
  logic              stepping;

  assign trial    = {rem_q, quo_q[DATA_W-1]} - {1'b0, dvs_q};
  assign finish   = busy && (cnt == CNT_W'(II - 1));
  assign stepping = busy && (cnt < CNT_W'(DATA_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (in_valid) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (finish) begin
        if (grant) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      quo_q <= in_a;
      rem_q <= '0;
      dvs_q <= in_b;
      tag_q <= in_tag;
    end else if (stepping) begin
      if (!trial[DATA_W]) begin
        rem_q <= trial[DATA_W-1:0];
        quo_q <= {quo_q[DATA_W-2:0], 1'b1};
      end else begin
        rem_q <= {rem_q[DATA_W-2:0], quo_q[DATA_W-1]};
        quo_q <= {quo_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign ready     = ~busy;
  assign out_valid = finish;
  assign out_tag   = tag_q;
  assign out_data  = quo_q;

  // R7: an accepted divide closes the unit on the very next cycle
  assert_window_opens_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!ready && cnt == '0));

  // R7: the unit reopens only after its result was handed over
  assert_reopen_after_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(out_valid && grant));
endmodule

// File: rtl/fu_wb_arb.sv
module fu_wb_arb
  import fu_pkg::*;
#(
  parameter int N      = NUM_UNITS,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N-1:0]                 req,
  input  logic [N-1:0][TAG_W-1:0]      req_tag,
  input  logic [N-1:0][DATA_W-1:0]     req_data,
  output logic [N-1:0]                 grant,
  output logic                         wb_valid,
  output logic [UNIT_W-1:0]            wb_unit,
  output logic [TAG_W-1:0]             wb_tag,
  output logic [DATA_W-1:0]            wb_data
);
  logic [UNIT_W-1:0] sel;
  logic              mem_valid;
  logic [UNIT_W-1:0] mem_unit;
  logic [TAG_W-1:0]  mem_tag;
  logic [DATA_W-1:0] mem_data;

  // highest index wins
  always_comb begin
    grant = '0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        sel      = UNIT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      wb_valid  <= 1'b0;
    end else begin
      mem_valid <= |req;
      wb_valid  <= mem_valid;
    end
  end

  always_ff @(posedge clk) begin
    mem_unit <= sel;
    mem_tag  <= req_tag[sel];
    mem_data <= req_data[sel];
    wb_unit  <= mem_unit;
    wb_tag   <= mem_tag;
    wb_data  <= mem_data;
  end

  // R8: never more than one unit granted
  assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R9: every completion came from a grant two cycles earlier
  assert_wb_from_grant_R9: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(|grant, 2));
endmodule

// File: rtl/fu_pool.sv
module fu_pool
  import fu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 6,
  parameter int LAT_INT = 0,
  parameter int LAT_LS  = 1,
  parameter int LAT_ADD = 3,
  parameter int LAT_MUL = 6,
  parameter int DIV_II  = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iss_valid,
  input  logic [UNIT_W-1:0]    iss_unit,
  input  logic [TAG_W-1:0]     iss_tag,
  input  logic [DATA_W-1:0]    iss_a,
  input  logic [DATA_W-1:0]    iss_b,
  output logic [NUM_UNITS-1:0] unit_ready,
  output logic                 wb_valid,
  output logic [UNIT_W-1:0]    wb_unit,
  output logic [TAG_W-1:0]     wb_tag,
  output logic [DATA_W-1:0]    wb_data
);
  localparam int NPIPE = NUM_UNITS - 1;

  function automatic int depth_of(input int u);
    case (u)
      0:       return LAT_INT + 1;
      1:       return LAT_LS + 1;
      2:       return LAT_ADD + 1;
      default: return LAT_MUL + 1;
    endcase
  endfunction

  logic [NUM_UNITS-1:0]             accept;
  logic [NUM_UNITS-1:0]             fin_valid;
  logic [NUM_UNITS-1:0]             grant;
  logic [NUM_UNITS-1:0][TAG_W-1:0]  fin_tag;
  logic [NUM_UNITS-1:0][DATA_W-1:0] fin_data;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_accept
    assign accept[g] = iss_valid && (iss_unit == UNIT_W'(g)) && unit_ready[g];
  end

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    fu_pipe #(
      .DEPTH (depth_of(g)),
      .DATA_W(DATA_W),
      .TAG_W (TAG_W),
      .KIND  (unit_e'(g))
    ) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .in_valid (accept[g]),
      .in_tag   (iss_tag),
      .in_a     (iss_a),
      .in_b     (iss_b),
      .grant    (grant[g]),
      .ready    (unit_ready[g]),
      .out_valid(fin_valid[g]),
      .out_tag  (fin_tag[g]),
      .out_data (fin_data[g])
    );
  end

  fu_div #(
    .DATA_W(DATA_W),
    .TAG_W (TAG_W),
    .II    (DIV_II)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .in_valid (accept[U_DIV]),
    .in_tag   (iss_tag),
    .in_a     (iss_a),
    .in_b     (iss_b),
    .grant    (grant[U_DIV]),
    .ready    (unit_ready[U_DIV]),
    .out_valid(fin_valid[U_DIV]),
    .out_tag  (fin_tag[U_DIV]),
    .out_data (fin_data[U_DIV])
  );

  fu_wb_arb #(
    .N     (NUM_UNITS),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (fin_valid),
    .req_tag (fin_tag),
    .req_data(fin_data),
    .grant   (grant),
    .wb_valid(wb_valid),
    .wb_unit (wb_unit),
    .wb_tag  (wb_tag),
    .wb_data (wb_data)
  );
endmodule

// File: tb/fu_pool_tb.sv
`timescale 1ns/1ps
module fu_pool_tb;
  localparam int DW = 16;
  localparam int TW = 6;

  typedef struct {
    int          unit;
    int          tag;
    logic [DW-1:0] data;
    int          due;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic [2:0]    iss_unit = '0;
  logic [TW-1:0] iss_tag = '0;
  logic [DW-1:0] iss_a = '0, iss_b = '0;
  logic [4:0]    unit_ready;
  logic          wb_valid;
  logic [2:0]    wb_unit;
  logic [TW-1:0] wb_tag;
  logic [DW-1:0] wb_data;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   wb_seen = 0;
  exp_t pend[$];

  fu_pool u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_unit(iss_unit),
    .iss_tag(iss_tag), .iss_a(iss_a), .iss_b(iss_b), .unit_ready(unit_ready),
    .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int delay_of(input int u);
    case (u)
      0: return 2;
      1: return 3;
      2: return 5;
      3: return 8;
      default: return 26;
    endcase
  endfunction

  function automatic logic [DW-1:0] model(input int u, input logic [DW-1:0] a, b);
    logic [2*DW-1:0] p;
    case (u)
      0: return a ^ b;
      3: begin p = a * b; return p[DW-1:0]; end
      4: return (b == 0) ? {DW{1'b1}} : a / b;
      default: return a + b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // driver: present one operation for one cycle, push what should come back
  task automatic issue(input int u, input int t, input logic [DW-1:0] a, b,
                       input int extra, input bit expect_ok, input string req);
    exp_t e;
    if (u < 5) check(unit_ready[u] == expect_ok, req, "ready at issue", int'(unit_ready[u]), int'(expect_ok));
    iss_valid = 1'b1;
    iss_unit  = 3'(u);
    iss_tag   = TW'(t);
    iss_a     = a;
    iss_b     = b;
    if (expect_ok) begin
      e.unit = u; e.tag = t; e.data = model(u, a, b);
      e.due  = cyc + 1 + delay_of(u) + extra; e.req = req;
      pend.push_back(e);
    end
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every completion with the oldest pending item of its unit
  always @(negedge clk) begin
    if (!rst && wb_valid) begin
      int found;
      found = -1;
      wb_seen++;
      for (int i = 0; i < pend.size(); i++) begin
        if (pend[i].unit == int'(wb_unit)) begin found = i; break; end
      end
      if (found < 0) begin
        check(1'b0, "R9", "unexpected completion from unit", int'(wb_unit), -1);
      end else begin
        exp_t e;
        e = pend[found];
        pend.delete(found);
        check(int'(wb_tag) == e.tag, e.req, "tag", int'(wb_tag), e.tag);
        check(wb_data == e.data, e.req, "data", int'(wb_data), int'(e.data));
        check(cyc == e.due, e.req, "arrival cycle", cyc, e.due);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int mark;
    repeat (3) @(negedge clk);
    check(unit_ready == 5'h1F, "R1", "ready in reset", int'(unit_ready), 31);
    check(wb_valid == 1'b0, "R1", "wb_valid in reset", int'(wb_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(unit_ready == 5'h1F, "R1", "ready after reset", int'(unit_ready), 31);
    check(wb_valid == 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);

    // single operations on each unit
    issue(0, 1, 16'hA5A5, 16'h0FF0, 0, 1, "R2"); idle(6);
    issue(1, 2, 16'h1234, 16'h0100, 0, 1, "R3"); idle(6);
    issue(2, 3, 16'hFFFF, 16'h0002, 0, 1, "R4"); idle(8);
    issue(3, 4, 16'h0123, 16'h0456, 0, 1, "R5"); idle(10);
    issue(4, 5, 16'd50000, 16'd7, 0, 1, "R6"); idle(30);
    issue(4, 6, 16'h8001, 16'h0000, 0, 1, "R6"); idle(30);

    // back-to-back on pipelined units
    issue(2, 7, 16'd10, 16'd20, 0, 1, "R4");
    issue(2, 8, 16'd30, 16'd40, 0, 1, "R4");
    issue(2, 9, 16'd50, 16'd60, 0, 1, "R4");
    idle(10);
    issue(3, 10, 16'd300, 16'd300, 0, 1, "R5");
    issue(3, 11, 16'hFFFF, 16'hFFFF, 0, 1, "R5");
    issue(3, 12, 16'd7, 16'd9, 0, 1, "R5");
    issue(0, 13, 16'h00FF, 16'h0F0F, 0, 1, "R9");
    idle(12);

    // divider window
    mark = cyc;
    issue(4, 14, 16'd1000, 16'd33, 0, 1, "R7");
    issue(4, 15, 16'd1, 16'd1, 0, 0, "R7");
    idle(mark + 25 - cyc);
    check(unit_ready[4] == 1'b0, "R7", "divider ready on 25th cycle", int'(unit_ready[4]), 0);
    idle(1);
    check(unit_ready[4] == 1'b1, "R7", "divider ready after window", int'(unit_ready[4]), 1);
    issue(4, 16, 16'd9, 16'd3, 0, 1, "R7");
    idle(30);

    // multiplier and integer finish together: multiplier wins
    issue(3, 17, 16'd5, 16'd6, 0, 1, "R8");
    idle(5);
    issue(0, 18, 16'h1111, 16'h2222, 1, 1, "R8");
    check(unit_ready[0] == 1'b0, "R8", "integer ready while held", int'(unit_ready[0]), 0);
    idle(1);
    check(unit_ready[0] == 1'b1, "R8", "integer ready after grant", int'(unit_ready[0]), 1);
    idle(10);

    // adder and load/store finish together: adder wins
    issue(2, 19, 16'd100, 16'd1, 0, 1, "R8");
    idle(1);
    issue(1, 20, 16'd200, 16'd2, 1, 1, "R8");
    idle(10);

    // divider and multiplier finish together: divider wins
    issue(4, 21, 16'd640, 16'd8, 0, 1, "R8");
    idle(17);
    issue(3, 22, 16'd11, 16'd12, 1, 1, "R8");
    idle(15);

    // out-of-range unit code
    mark = wb_seen;
    issue(5, 23, 16'd1, 16'd2, 0, 0, "R10");
    issue(7, 24, 16'd3, 16'd4, 0, 0, "R10");
    check(unit_ready == 5'h1F, "R10", "ready after bad code", int'(unit_ready), 31);
    idle(30);
    check(wb_seen == mark, "R10", "completions after bad code", wb_seen - mark, 0);

    idle(5);
    check(pend.size() == 0, "R9", "pending items left", pend.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule